// File: doc/BRIEF.md
# System Exception Pending Control Register

This block is a 32-bit control and status register inside a small processor's exception unit. It holds the pending state of three system exceptions: the non-maskable interrupt, a software-requested deferred service call, and a periodic tick exception. Software changes these flags through a simple register bus. A single write strobe qualifies the write data word. Some bit positions set a flag when written with 1. Others clear a flag when written with 1. A bit written with 0 changes nothing.

Each pending flag clears when the core reports, with a one-cycle pulse, that it has entered the matching handler. The non-maskable flag can also be raised by a hardware request input. A request that arrives while the core enters the handler leaves the flag set, so software sees the new request.

The read word joins the three flags with status that the exception unit supplies: the active exception number, the highest-priority pending exception number, an external-interrupt-pending flag, a preempted-exceptions flag and a debug-only bit. The pending number reads 0 when the base-priority mask or the fault mask blocks that exception. The primary interrupt mask is not applied to it, so the block has no input for that mask. Reads are combinational from the current state and status inputs. A write becomes visible in the read word on the cycle after its clock edge.

Top module: `sysexc_pend_reg`

## Requirements
- R1: After reset all three pending flags are 0, and with all status inputs at 0 the read word is 0.
- R2: A write with bit 31 at 1 sets the non-maskable pending flag, which reads back at bit 31. A write with 0 in the set and clear positions leaves every flag unchanged.
- R3: A cycle with `nmi_req` high sets the non-maskable flag. A `nmi_entry` pulse clears it, unless `nmi_req` is high in the same cycle, in which case the flag stays 1.
- R4: Writing 1 to bit 28 sets the deferred-call flag, which reads at bit 28. Writing 1 to bit 27 clears it. Bit 27 always reads 0.
- R5: Writing 1 to bit 26 sets the tick flag, which reads at bit 26. Writing 1 to bit 25 clears it. Bit 25 always reads 0.
- R6: When one write carries 1 in both the set bit and the clear bit of the same exception, the flag ends at 0.
- R7: An entry pulse clears only its own exception's flag. A write that sets a flag in the same cycle as that flag's entry pulse leaves the flag at 1.
- R8: Bits 30:29, 24, 21:18 and 10:9 always read 0.
- R9: Bit 23 reads `dbg_flag` while `core_halted` is 1, and reads 0 otherwise.
- R10: Bit 22 reads `ext_irq_pend`, bit 11 reads `preempted`, and bits 8:0 read `active_num`.
- R11: Bits 17:12 read `top_pend_num`, or 0 when `top_blk_base` or `top_blk_fault` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe for this register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| nmi_req | input | 1 | Hardware non-maskable request |
| nmi_entry | input | 1 | Pulse: core entered the non-maskable handler |
| call_entry | input | 1 | Pulse: core entered the deferred-call handler |
| tick_entry | input | 1 | Pulse: core entered the tick handler |
| core_halted | input | 1 | Core is in debug state |
| dbg_flag | input | 1 | Debug-only status bit |
| ext_irq_pend | input | 1 | An external interrupt is pending (no NMI or faults) |
| top_pend_num | input | 6 | Highest-priority pending exception number |
| top_blk_base | input | 1 | That exception is blocked by the base-priority mask |
| top_blk_fault | input | 1 | That exception is blocked by the fault mask |
| preempted | input | 1 | Preempted active exceptions exist |
| active_num | input | 9 | Active exception number |

## Verification
Directed writes first try single set bits, then single clear bits, then writes of all zeros. These separate each flag's set path from its clear path and show that a write of 0 does nothing. Set and clear bits written together, and the all-ones word, show that clear wins and that write-only and reserved positions read 0. Entry pulses are given alone, then with a same-cycle write set or hardware request. This separates the handler-entry clear from the priority rule that keeps a new request. A fixed-seed random run then mixes writes, entry pulses and status values, and compares every cycle's read word with a bench model. Changing the mask and debug inputs shows whether the read path gates the pending number and the debug bit.

// File: rtl/sysexc_pkg.sv
package sysexc_pkg;
  localparam int REG_W   = 32;
  localparam int ACT_W   = 9;
  localparam int PEND_W  = 6;
  localparam int NUM_EXC = 3;

  // Bit positions that software and the exception unit rely on
  localparam int POS_NMI_SET  = 31;
  localparam int POS_CALL_SET = 28;
  localparam int POS_CALL_CLR = 27;
  localparam int POS_TICK_SET = 26;
  localparam int POS_TICK_CLR = 25;
  localparam int POS_DBG      = 23;
  localparam int POS_IRQ      = 22;
  localparam int POS_PEND_LSB = 12;
  localparam int POS_PREEMPT  = 11;

  typedef enum logic [1:0] {
    EXC_NMI  = 2'd0,
    EXC_CALL = 2'd1,
    EXC_TICK = 2'd2
  } exc_kind_e;

  function automatic int set_pos(input int idx);
    case (idx)
      0:       set_pos = POS_NMI_SET;
      1:       set_pos = POS_CALL_SET;
      default: set_pos = POS_TICK_SET;
    endcase
  endfunction

  // Index 0 (non-maskable) has no software clear; returns 0 and is unused
  function automatic int clr_pos(input int idx);
    case (idx)
      1:       clr_pos = POS_CALL_CLR;
      2:       clr_pos = POS_TICK_CLR;
      default: clr_pos = 0;
    endcase
  endfunction

  // Software clear beats any set; any set beats handler-entry clear
  function automatic logic pend_next(input logic cur, input logic sw_set,
                                     input logic sw_clr, input logic hw_set,
                                     input logic entry_clr);
    if (sw_clr)                 pend_next = 1'b0;
    else if (sw_set || hw_set)  pend_next = 1'b1;
    else if (entry_clr)         pend_next = 1'b0;
    else                        pend_next = cur;
  endfunction

  // Pending number as reported: the base and fault masks apply, primary does not
  function automatic logic [PEND_W-1:0] pend_field(input logic [PEND_W-1:0] num,
                                                   input logic blk_base,
                                                   input logic blk_fault);
    pend_field = (blk_base || blk_fault) ? '0 : num;
  endfunction
endpackage

// File: rtl/sysexc_pend_flag.sv
module sysexc_pend_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic hw_set,
  input  logic entry_clr,
  output logic pend
);
  import sysexc_pkg::*;

  logic pend_d;
  logic quiet;

  assign pend_d = pend_next(pend, sw_set, sw_clr, hw_set, entry_clr);
  assign quiet  = !sw_set && !sw_clr && !hw_set && !entry_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_d;
  end

  // R6: clear wins over a same-cycle set
  assert_clr_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr |=> !pend);
  // R4 (also R2, R5): a software set without clear leaves the flag pending
  assert_sw_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_set && !sw_clr) |=> pend);
  // R3: a hardware request sets the flag even during handler entry
  assert_hw_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set && !sw_clr) |=> pend);
  // R7: an entry pulse alone clears the flag
  assert_entry_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_clr && !sw_set && !hw_set && !sw_clr) |=> !pend);
  // R2: no request of any kind leaves the flag unchanged
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> $stable(pend));
endmodule

// File: rtl/sysexc_rd_mux.sv
module sysexc_rd_mux #(
  parameter int REG_W  = sysexc_pkg::REG_W,
  parameter int ACT_W  = sysexc_pkg::ACT_W,
  parameter int PEND_W = sysexc_pkg::PEND_W,
  parameter int N_EXC  = sysexc_pkg::NUM_EXC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EXC-1:0]  pend_vec,
  input  logic              core_halted,
  input  logic              dbg_flag,
  input  logic              ext_irq_pend,
  input  logic [PEND_W-1:0] top_pend_num,
  input  logic              top_blk_base,
  input  logic              top_blk_fault,
  input  logic              preempted,
  input  logic [ACT_W-1:0]  active_num,
  output logic [REG_W-1:0]  rdata
);
  import sysexc_pkg::*;

  localparam logic [REG_W-1:0] RSVD_MASK =
    (REG_W'(3) << 29) | (REG_W'(1) << 24) | (REG_W'(15) << 18) | (REG_W'(3) << 9);

  logic [PEND_W-1:0] pend_shown;
  logic              dbg_shown;

  assign pend_shown = pend_field(top_pend_num, top_blk_base, top_blk_fault);
  assign dbg_shown  = core_halted & dbg_flag;

  always_comb begin
    rdata = '0;
    rdata[POS_NMI_SET]  = pend_vec[EXC_NMI];
    rdata[POS_CALL_SET] = pend_vec[EXC_CALL];
    rdata[POS_TICK_SET] = pend_vec[EXC_TICK];
    rdata[POS_DBG]      = dbg_shown;
    rdata[POS_IRQ]      = ext_irq_pend;
    rdata[POS_PEND_LSB +: PEND_W] = pend_shown;
    rdata[POS_PREEMPT]  = preempted;
    rdata[ACT_W-1:0]    = active_num;
  end

  // R8: reserved positions and write-only clear bits read 0
  assert_rsvd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((rdata & RSVD_MASK) == '0) && !rdata[POS_CALL_CLR] && !rdata[POS_TICK_CLR]);
  // R9: the debug bit is hidden outside debug state
  assert_dbg_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !core_halted |-> !rdata[POS_DBG]);
  // R11: a masked pending exception reports number 0
  assert_pend_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (top_blk_base || top_blk_fault) |-> (rdata[POS_PEND_LSB +: PEND_W] == '0));
endmodule

// File: rtl/sysexc_pend_reg.sv
module sysexc_pend_reg #(
  parameter int REG_W  = sysexc_pkg::REG_W,
  parameter int ACT_W  = sysexc_pkg::ACT_W,
  parameter int PEND_W = sysexc_pkg::PEND_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              nmi_req,
  input  logic              nmi_entry,
  input  logic              call_entry,
  input  logic              tick_entry,
  input  logic              core_halted,
  input  logic              dbg_flag,
  input  logic              ext_irq_pend,
  input  logic [PEND_W-1:0] top_pend_num,
  input  logic              top_blk_base,
  input  logic              top_blk_fault,
  input  logic              preempted,
  input  logic [ACT_W-1:0]  active_num
);
  import sysexc_pkg::*;

  localparam int N_EXC = NUM_EXC;

  // Named internal events, one bit per exception kind
  logic [N_EXC-1:0] wr_set;
  logic [N_EXC-1:0] wr_clr;
  logic [N_EXC-1:0] hw_set;
  logic [N_EXC-1:0] entry;
  logic [N_EXC-1:0] pend_vec;

  assign entry  = {tick_entry, call_entry, nmi_entry};
  assign hw_set = {{(N_EXC-1){1'b0}}, nmi_req};

  for (genvar i = 0; i < N_EXC; i++) begin : g_exc
    assign wr_set[i] = reg_wr & reg_wdata[set_pos(i)];
    if (i == int'(EXC_NMI)) begin : g_noclr
      assign wr_clr[i] = 1'b0;
    end else begin : g_clr
      assign wr_clr[i] = reg_wr & reg_wdata[clr_pos(i)];
    end

    sysexc_pend_flag u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_set    (wr_set[i]),
      .sw_clr    (wr_clr[i]),
      .hw_set    (hw_set[i]),
      .entry_clr (entry[i]),
      .pend      (pend_vec[i])
    );
  end

  sysexc_rd_mux #(
    .REG_W  (REG_W),
    .ACT_W  (ACT_W),
    .PEND_W (PEND_W),
    .N_EXC  (N_EXC)
  ) u_rd (
    .clk          (clk),
    .rst_n        (rst_n),
    .pend_vec     (pend_vec),
    .core_halted  (core_halted),
    .dbg_flag     (dbg_flag),
    .ext_irq_pend (ext_irq_pend),
    .top_pend_num (top_pend_num),
    .top_blk_base (top_blk_base),
    .top_blk_fault(top_blk_fault),
    .preempted    (preempted),
    .active_num   (active_num),
    .rdata        (reg_rdata)
  );

  // R3: a hardware request is visible in the read word on the next cycle
  assert_nmi_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> reg_rdata[POS_NMI_SET]);
  // R7: an entry pulse for one exception leaves the other flags alone
  assert_entry_local_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (call_entry && !reg_wr && !tick_entry) |=> $stable(pend_vec[EXC_TICK]));
  // R1: the flags are clear in the first cycle after reset
  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (pend_vec == '0));
endmodule

// File: tb/sysexc_pend_reg_bench.sv
module sysexc_pend_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        nmi_req = 1'b0, nmi_entry = 1'b0, call_entry = 1'b0, tick_entry = 1'b0;
  logic        core_halted = 1'b0, dbg_flag = 1'b0, ext_irq_pend = 1'b0;
  logic [5:0]  top_pend_num = '0;
  logic        top_blk_base = 1'b0, top_blk_fault = 1'b0, preempted = 1'b0;
  logic [8:0]  active_num = '0;

  int checks = 0;
  int failures = 0;
  logic m_nmi = 1'b0, m_call = 1'b0, m_tick = 1'b0;

  always #5 clk = ~clk;

  sysexc_pend_reg u_sysexc_pend_reg (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .nmi_req(nmi_req), .nmi_entry(nmi_entry),
    .call_entry(call_entry), .tick_entry(tick_entry), .core_halted(core_halted),
    .dbg_flag(dbg_flag), .ext_irq_pend(ext_irq_pend), .top_pend_num(top_pend_num),
    .top_blk_base(top_blk_base), .top_blk_fault(top_blk_fault),
    .preempted(preempted), .active_num(active_num)
  );

  // Flag update restated: start from the set/entry outcome, then apply the clear
  function automatic logic flag_model(input logic cur, input logic set,
                                      input logic entry_p, input logic clr);
    logic n;
    n = cur;
    if (set) n = 1'b1;
    else if (entry_p) n = 1'b0;
    if (clr) n = 1'b0;
    return n;
  endfunction

  function automatic logic [31:0] expected_word();
    logic [31:0] w;
    w = 32'(active_num);
    w = w + (32'(preempted) << 11);
    if (!(top_blk_base | top_blk_fault)) w = w + (32'(top_pend_num) << 12);
    w = w + (32'(ext_irq_pend) << 22);
    w = w + (32'(core_halted & dbg_flag) << 23);
    w = w + (32'(m_tick) << 26) + (32'(m_call) << 28) + (32'(m_nmi) << 31);
    return w;
  endfunction

  task automatic check_word(input string req);
    logic [31:0] e;
    e = expected_word();
    checks++;
    if (reg_rdata !== e) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, reg_rdata, e);
    end
  endtask

  task automatic step(input logic wr, input logic [31:0] wd, input logic nr,
                      input logic ne, input logic ce, input logic te);
    @(negedge clk);
    reg_wr = wr; reg_wdata = wd; nmi_req = nr;
    nmi_entry = ne; call_entry = ce; tick_entry = te;
    @(posedge clk);
    m_nmi  = flag_model(m_nmi,  (wr & wd[31]) | nr, ne, 1'b0);
    m_call = flag_model(m_call, wr & wd[28], ce, wr & wd[27]);
    m_tick = flag_model(m_tick, wr & wd[26], te, wr & wd[25]);
    #1;
    reg_wr = 1'b0; reg_wdata = '0; nmi_req = 1'b0;
    nmi_entry = 1'b0; call_entry = 1'b0; tick_entry = 1'b0;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #2;
    check_word("R1 during reset");
    rst_n = 1'b1;
    @(posedge clk); #2;
    check_word("R1 after reset");

    step(1, 32'h8000_0000, 0, 0, 0, 0); check_word("R2 set nmi");
    step(1, 32'h0000_0000, 0, 0, 0, 0); check_word("R2 zero write");
    step(0, 32'h0,         0, 1, 0, 0); check_word("R3 entry clears");
    step(0, 32'h0,         1, 0, 0, 0); check_word("R3 hw request");
    step(0, 32'h0,         1, 1, 0, 0); check_word("R3 request during entry");
    step(0, 32'h0,         0, 1, 0, 0); check_word("R3 entry clears again");

    step(1, 32'h1000_0000, 0, 0, 0, 0); check_word("R4 set call");
    step(1, 32'h0800_0000, 0, 0, 0, 0); check_word("R4 clear call");
    step(1, 32'h0400_0000, 0, 0, 0, 0); check_word("R5 set tick");
    step(1, 32'h0200_0000, 0, 0, 0, 0); check_word("R5 clear tick");
    step(1, 32'h1400_0000, 0, 0, 0, 0); check_word("R6 set both");
    step(1, 32'h0600_0000, 0, 0, 0, 0); check_word("R6 tick set+clr");
    step(1, 32'h1800_0000, 0, 0, 0, 0); check_word("R6 call set+clr");
    step(1, 32'h1000_0000, 0, 0, 0, 0); check_word("R7 prep");
    step(1, 32'h0400_0000, 0, 0, 1, 0); check_word("R7 entry only own flag");
    step(1, 32'h0400_0000, 0, 0, 0, 1); check_word("R7 set beats entry");
    step(1, 32'hFFFF_FFFF, 0, 0, 0, 0); check_word("R8 all ones write");

    dbg_flag = 1'b1; #1; check_word("R9 hidden outside debug");
    core_halted = 1'b1; #1; check_word("R9 shown in debug");
    ext_irq_pend = 1'b1; preempted = 1'b1; active_num = 9'h1A5; #1;
    check_word("R10 status fields");
    top_pend_num = 6'h2B; top_blk_base = 1'b1; #1; check_word("R11 base mask");
    top_blk_base = 1'b0; top_blk_fault = 1'b1; #1; check_word("R11 fault mask");
    top_blk_fault = 1'b0; #1; check_word("R11 unmasked");

    for (int n = 0; n < 400; n++) begin
      core_halted  = 1'($urandom);
      dbg_flag     = 1'($urandom);
      ext_irq_pend = 1'($urandom);
      top_pend_num = 6'($urandom);
      top_blk_base = ($urandom % 4) == 0;
      top_blk_fault = ($urandom % 4) == 0;
      preempted    = 1'($urandom);
      active_num   = 9'($urandom);
      step(($urandom % 2) == 0, $urandom, ($urandom % 8) == 0,
           ($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0);
      check_word("R6 R7 R10 R11 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule